// File: doc/BRIEF.md
# Bootloader Host Frame Receiver

This block sits behind a UART byte receiver and pulls host-to-device command frames out of the incoming byte stream. A frame opens with the two-byte marker 0x46 0xB9. A direction byte, a 16-bit length, the payload, a 16-bit checksum and a closing 0x16 follow. The block checks every one of these fields as the bytes arrive. It stores the payload bytes in a local buffer and reports the first payload byte as the command type.

When a frame is accepted, a one-cycle pulse marks success. The command type and the payload length stay on the outputs, and the buffer can be read through a synchronous read port. Any fault produces a one-cycle error strobe with a code that names the failing field. The parser then goes back to searching for the first marker byte. Bit-level UART reception, the execution of commands and the building of replies belong to other blocks.

Top module: `bl_frame_rx`

## Requirements
- R1: After reset, frame_ok, err_stb and pay_valid are 0 and err_code is 0.
- R2: While hunting, every byte other than 0x46 is dropped silently. After a 0x46, a byte that is neither 0xB9 nor 0x46 gives error code 1 (marker).
- R3: A second 0x46 in place of 0xB9 is taken as a fresh first marker and raises no error, so 0x46 0x46 0xB9 opens a frame.
- R4: The byte after the marker must be 0x6A. Any other value gives error code 2 (direction).
- R5: The next two bytes form a big-endian length L that covers the direction byte through the end byte, so the payload holds L-6 bytes. If L < 7 or L-6 > PAYLOAD_MAX, error code 3 (length) is raised as soon as the low length byte arrives.
- R6: After the payload comes a big-endian 16-bit checksum. It must equal the sum modulo 65536 of every byte from the direction byte through the last payload byte. A mismatch gives error code 4 (checksum) when the low checksum byte arrives.
- R7: The byte after the checksum must be 0x16. Any other value gives error code 5 (end).
- R8: frame_ok and err_stb are single-cycle pulses. Each rises in the cycle after the clock edge that accepted the deciding byte, and the two are never high together. err_code carries the code only while err_stb is high and reads 0 otherwise.
- R9: When frame_ok pulses, cmd_type takes the first payload byte and pay_len takes L-6. Both then hold through later failed frames until the next accepted frame.
- R10: pay_valid rises together with frame_ok. It falls in the cycle after a 0x46 is accepted while hunting. Payload byte i can be read at rd_addr = i, and rd_data shows it one cycle later.
- R11: After any error, the parser hunts again. The byte that caused the error is not reconsidered as a marker.
- R12: Cycles with in_valid low have no effect on parsing, however many there are between bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | in_byte holds a received byte this cycle |
| in_byte | input | 8 | Received byte |
| rd_addr | input | $clog2(PAYLOAD_MAX) | Payload buffer read index |
| rd_data | output | 8 | Payload byte at rd_addr, one cycle later |
| frame_ok | output | 1 | Pulse: a frame passed all checks |
| err_stb | output | 1 | Pulse: a frame was rejected |
| err_code | output | 3 | Failure code while err_stb is high, else 0 |
| cmd_type | output | 8 | First payload byte of the last accepted frame |
| pay_len | output | $clog2(PAYLOAD_MAX+1) | Payload length of the last accepted frame |
| pay_valid | output | 1 | Buffer holds the last accepted payload |

## Verification
The bench builds the block with PAYLOAD_MAX set to 16. With that setting, frames that fill the buffer exactly and frames one byte too long take only a few dozen cycles each, so both sides of the length limit are tested. A 16-byte payload of 0xFF bytes pushes the checksum well beyond 8 bits, which exercises the carry into the high checksum byte. Gaps of idle cycles, a doubled first marker and error frames placed between good frames test the restart behaviour, and they confirm that the held results survive a rejected frame.

// File: rtl/blfr_pkg.sv
package blfr_pkg;

  typedef enum logic [3:0] {
    S_HUNT, S_MK2, S_DIR, S_LENH, S_LENL, S_PAY, S_CKH, S_CKL, S_END
  } blfr_state_e;

  localparam logic [7:0] MARK_A   = 8'h46;
  localparam logic [7:0] MARK_B   = 8'hB9;
  localparam logic [7:0] DIR_H2D  = 8'h6A;
  localparam logic [7:0] END_BYTE = 8'h16;

  localparam logic [2:0] ERR_NONE  = 3'd0;
  localparam logic [2:0] ERR_MARK  = 3'd1;
  localparam logic [2:0] ERR_DIR   = 3'd2;
  localparam logic [2:0] ERR_LEN   = 3'd3;
  localparam logic [2:0] ERR_CKSUM = 3'd4;
  localparam logic [2:0] ERR_END   = 3'd5;

  // Framing overhead counted by the length field besides the payload
  localparam int FRAME_OVH = 6;

  function automatic logic [15:0] sum_add(input logic [15:0] s, input logic [7:0] b);
    return s + {8'h00, b};
  endfunction

  function automatic logic len_fits(input logic [15:0] len, input int cap);
    return (int'(len) >= FRAME_OVH + 1) && (int'(len) <= cap + FRAME_OVH);
  endfunction

endpackage

// File: rtl/blfr_parser.sv
module blfr_parser
  import blfr_pkg::*;
#(
  parameter int PAYLOAD_MAX = 256,
  localparam int AW = $clog2(PAYLOAD_MAX),
  localparam int LW = $clog2(PAYLOAD_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  output logic          ev_hunt_start,
  output logic          ev_wr,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          ev_good,
  output logic          ev_err,
  output logic [2:0]    ev_code,
  output logic [7:0]    cur_cmd,
  output logic [LW-1:0] cur_plen
);

  blfr_state_e st, st_nx;
  logic [7:0]    len_hi;
  logic [7:0]    ck_hi;
  logic [15:0]   sum;
  logic [LW-1:0] cnt;
  logic [LW-1:0] plen;
  logic [15:0]   len_full;

  assign len_full = {len_hi, in_byte};
  assign wr_addr  = AW'(cnt);
  assign wr_data  = in_byte;
  assign cur_plen = plen;

  always_comb begin
    st_nx         = st;
    ev_hunt_start = 1'b0;
    ev_wr         = 1'b0;
    ev_good       = 1'b0;
    ev_err        = 1'b0;
    ev_code       = ERR_NONE;
    if (in_valid) begin
      unique case (st)
        S_HUNT: if (in_byte == MARK_A) begin
          st_nx = S_MK2;
          ev_hunt_start = 1'b1;
        end
        S_MK2: begin
          if (in_byte == MARK_B) st_nx = S_DIR;
          else if (in_byte != MARK_A) begin
            st_nx = S_HUNT; ev_err = 1'b1; ev_code = ERR_MARK;
          end
        end
        S_DIR: begin
          if (in_byte == DIR_H2D) st_nx = S_LENH;
          else begin
            st_nx = S_HUNT; ev_err = 1'b1; ev_code = ERR_DIR;
          end
        end
        S_LENH: st_nx = S_LENL;
        S_LENL: begin
          if (len_fits(len_full, PAYLOAD_MAX)) st_nx = S_PAY;
          else begin
            st_nx = S_HUNT; ev_err = 1'b1; ev_code = ERR_LEN;
          end
        end
        S_PAY: begin
          ev_wr = 1'b1;
          if (cnt == plen - LW'(1)) st_nx = S_CKH;
        end
        S_CKH: st_nx = S_CKL;
        S_CKL: begin
          if ({ck_hi, in_byte} == sum) st_nx = S_END;
          else begin
            st_nx = S_HUNT; ev_err = 1'b1; ev_code = ERR_CKSUM;
          end
        end
        S_END: begin
          st_nx = S_HUNT;
          if (in_byte == END_BYTE) ev_good = 1'b1;
          else begin
            ev_err = 1'b1; ev_code = ERR_END;
          end
        end
        default: st_nx = S_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_HUNT;
      len_hi  <= '0;
      ck_hi   <= '0;
      sum     <= '0;
      cnt     <= '0;
      plen    <= '0;
      cur_cmd <= '0;
    end else begin
      st <= st_nx;
      if (in_valid) begin
        unique case (st)
          S_DIR:  sum <= {8'h00, in_byte};
          S_LENH: begin
            len_hi <= in_byte;
            sum    <= sum_add(sum, in_byte);
          end
          S_LENL: begin
            sum  <= sum_add(sum, in_byte);
            plen <= LW'(len_full - 16'(FRAME_OVH));
            cnt  <= '0;
          end
          S_PAY: begin
            sum <= sum_add(sum, in_byte);
            cnt <= cnt + LW'(1);
            if (cnt == '0) cur_cmd <= in_byte;
          end
          S_CKH: ck_hi <= in_byte;
          default: ;
        endcase
      end
    end
  end

  AST_GOOD_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_good && ev_err)) else $error("good and error together"); // R8
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAY) |-> (cnt < plen)) else $error("payload index overrun"); // R5
  AST_PLEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAY) |-> (plen >= LW'(1) && int'(plen) <= PAYLOAD_MAX)) else $error("payload length out of range"); // R5
  AST_WR_ONLY_PAY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |-> (st == S_PAY && in_valid)) else $error("stray buffer write"); // R12

endmodule

// File: rtl/blfr_buf.sv
module blfr_buf #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [7:0]    wd,
  input  logic [AW-1:0] ra,
  output logic [7:0]    rd
);

  logic [7:0] mem [DEPTH];

  // Read returns the old contents when the same address is written
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end

endmodule

// File: rtl/bl_frame_rx.sv
module bl_frame_rx
  import blfr_pkg::*;
#(
  parameter int PAYLOAD_MAX = 256,
  localparam int AW = $clog2(PAYLOAD_MAX),
  localparam int LW = $clog2(PAYLOAD_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          frame_ok,
  output logic          err_stb,
  output logic [2:0]    err_code,
  output logic [7:0]    cmd_type,
  output logic [LW-1:0] pay_len,
  output logic          pay_valid
);

  logic          ev_hunt_start, ev_wr, ev_good, ev_err;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data, cur_cmd;
  logic [2:0]    ev_code;
  logic [LW-1:0] cur_plen;

  blfr_parser #(.PAYLOAD_MAX(PAYLOAD_MAX)) u_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .ev_hunt_start(ev_hunt_start), .ev_wr(ev_wr), .wr_addr(wr_addr),
    .wr_data(wr_data), .ev_good(ev_good), .ev_err(ev_err),
    .ev_code(ev_code), .cur_cmd(cur_cmd), .cur_plen(cur_plen)
  );

  blfr_buf #(.DEPTH(PAYLOAD_MAX)) u_buf (
    .clk(clk), .we(ev_wr), .wa(wr_addr), .wd(wr_data),
    .ra(rd_addr), .rd(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_ok  <= 1'b0;
      err_stb   <= 1'b0;
      err_code  <= ERR_NONE;
      cmd_type  <= '0;
      pay_len   <= '0;
      pay_valid <= 1'b0;
    end else begin
      frame_ok <= ev_good;
      err_stb  <= ev_err;
      err_code <= ev_err ? ev_code : ERR_NONE;
      if (ev_good) begin
        cmd_type  <= cur_cmd;
        pay_len   <= cur_plen;
        pay_valid <= 1'b1;
      end else if (ev_hunt_start) begin
        pay_valid <= 1'b0;
      end
    end
  end

  AST_OK_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> $past(in_valid && in_byte == END_BYTE)) else $error("accept without end byte"); // R7
  AST_OK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !frame_ok) else $error("frame_ok longer than one cycle"); // R8
  AST_NO_OK_AND_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ok && err_stb)) else $error("accept and reject together"); // R8
  AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    err_stb |-> (err_code != ERR_NONE)) else $error("error without code"); // R8
  AST_PV_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pay_valid) |-> frame_ok) else $error("pay_valid rose without accept"); // R10
  AST_LEN_ON_OK: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> (pay_len != '0 && int'(pay_len) <= PAYLOAD_MAX)) else $error("bad reported length"); // R5

endmodule

// File: tb/sim_bl_frame_rx.sv
`timescale 1ns/1ps
module sim_bl_frame_rx;
  localparam int PM = 16;
  localparam int AW = $clog2(PM);
  localparam int LW = $clog2(PM + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic frame_ok, err_stb, pay_valid;
  logic [2:0] err_code;
  logic [7:0] cmd_type;
  logic [LW-1:0] pay_len;

  always #2 clk = ~clk;

  bl_frame_rx #(.PAYLOAD_MAX(PM)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .rd_addr(rd_addr), .rd_data(rd_data), .frame_ok(frame_ok),
    .err_stb(err_stb), .err_code(err_code), .cmd_type(cmd_type),
    .pay_len(pay_len), .pay_valid(pay_valid)
  );

  int n_checks = 0;
  int n_errs = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_st, m_lenh, m_len, m_plen, m_cnt, m_sum, m_ckh, m_cmd;
  int mem [PM];
  bit known [PM];
  int exp_ok, exp_es, exp_ec, exp_cmd, exp_len, exp_pv, exp_rd;
  bit exp_rd_known;
  bit model_live = 0;

  task automatic model_err(input int code);
    exp_es = 1; exp_ec = code; m_st = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_sum = 0; m_cmd = 0;
      exp_ok = 0; exp_es = 0; exp_ec = 0; exp_cmd = 0; exp_len = 0; exp_pv = 0;
      exp_rd_known = 0;
      foreach (known[i]) known[i] = 0;
    end else begin
      int b;
      exp_ok = 0; exp_es = 0; exp_ec = 0;
      exp_rd = mem[int'(rd_addr)];
      exp_rd_known = known[int'(rd_addr)];
      b = int'(in_byte);
      if (in_valid) begin
        case (m_st)
          0: if (b == 'h46) begin m_st = 1; exp_pv = 0; end
          1: if (b == 'hB9) m_st = 2; else if (b != 'h46) model_err(1);
          2: if (b == 'h6A) begin m_sum = b; m_st = 3; end else model_err(2);
          3: begin m_lenh = b; m_sum += b; m_st = 4; end
          4: begin
            m_len = m_lenh * 256 + b; m_sum += b;
            if (m_len < 7 || m_len - 6 > PM) model_err(3);
            else begin m_plen = m_len - 6; m_cnt = 0; m_st = 5; end
          end
          5: begin
            mem[m_cnt] = b; known[m_cnt] = 1;
            if (m_cnt == 0) m_cmd = b;
            m_sum = (m_sum + b) % 65536;
            m_cnt++;
            if (m_cnt == m_plen) m_st = 6;
          end
          6: begin m_ckh = b; m_st = 7; end
          7: if (m_ckh * 256 + b == m_sum % 65536) m_st = 8; else model_err(4);
          default: begin
            m_st = 0;
            if (b == 'h16) begin
              exp_ok = 1; exp_cmd = m_cmd; exp_len = m_plen; exp_pv = 1;
            end else model_err(5);
          end
        endcase
      end
    end
  end

  // ---------------- per-cycle comparison and event capture ----------------
  int last_err = 0;
  int n_ok = 0;
  always @(negedge clk) begin
    if (rst_n && model_live) begin
      chk(frame_ok == 1'(exp_ok), "R8", "frame_ok", int'(frame_ok), exp_ok);
      chk(err_stb == 1'(exp_es), "R8", "err_stb", int'(err_stb), exp_es);
      chk(int'(err_code) == exp_ec, "R8", "err_code", int'(err_code), exp_ec);
      chk(int'(cmd_type) == exp_cmd, "R9", "cmd_type", int'(cmd_type), exp_cmd);
      chk(int'(pay_len) == exp_len, "R9", "pay_len", int'(pay_len), exp_len);
      chk(pay_valid == 1'(exp_pv), "R10", "pay_valid", int'(pay_valid), exp_pv);
      if (exp_rd_known)
        chk(int'(rd_data) == exp_rd, "R10", "rd_data", int'(rd_data), exp_rd);
      if (err_stb) last_err = int'(err_code);
      if (frame_ok) n_ok++;
    end
  end

  // ---------------- stimulus ----------------
  int gap_every = 0;
  int put_cnt = 0;
  logic [7:0] pq [$];

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); in_valid = 1'b0; end
  endtask

  task automatic put(input logic [7:0] b);
    put_cnt++;
    if (gap_every > 0 && put_cnt % gap_every == 0) idle(2);
    @(negedge clk); in_valid = 1'b1; in_byte = b;
  endtask

  // lenv < 0: correct length; nbytes < 0: send whole frame
  task automatic send_frame(input logic [7:0] dir, input int lenv, input bit bad_ck,
                            input logic [7:0] endb, input int nbytes);
    logic [7:0] fr [$];
    int len, s;
    len = (lenv < 0) ? pq.size() + 6 : lenv;
    fr = {8'h46, 8'hB9, dir, 8'(len >> 8), 8'(len)};
    s = int'(dir) + (len >> 8) % 256 + len % 256;
    foreach (pq[i]) begin fr.push_back(pq[i]); s += int'(pq[i]); end
    s = s % 65536;
    if (bad_ck) s = s ^ 1;
    fr.push_back(8'(s >> 8)); fr.push_back(8'(s)); fr.push_back(endb);
    foreach (fr[i]) if (nbytes < 0 || i < nbytes) put(fr[i]);
    idle(3);
  endtask

  task automatic expect_result(input int code, input int oks, input string req);
    chk(last_err == code, req, "last error code", last_err, code);
    chk(n_ok == oks, req, "accepted frames", n_ok, oks);
  endtask

  task automatic readback(input string req);
    foreach (pq[i]) begin
      @(negedge clk); in_valid = 1'b0; rd_addr = AW'(i);
      @(negedge clk);
      chk(rd_data == pq[i], req, "payload byte", int'(rd_data), int'(pq[i]));
    end
  endtask

  initial begin
    int oks;
    oks = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(frame_ok == 0 && err_stb == 0, "R1", "pulses at reset", int'({frame_ok, err_stb}), 0);
    chk(err_code == 0, "R1", "err_code at reset", int'(err_code), 0);
    chk(pay_valid == 0, "R1", "pay_valid at reset", int'(pay_valid), 0);
    rst_n = 1'b1;
    model_live = 1;
    idle(2);

    // R6/R9/R10: good frame with 4-byte payload
    pq = {8'h84, 8'h01, 8'h02, 8'h03};
    send_frame(8'h6A, -1, 0, 8'h16, -1); oks++;
    expect_result(0, oks, "R9");
    chk(cmd_type == 8'h84, "R9", "command type", int'(cmd_type), 'h84);
    chk(int'(pay_len) == 4, "R5", "payload length", int'(pay_len), 4);
    readback("R10");

    // R5: one-byte payload (smallest legal length 7)
    pq = {8'h82};
    send_frame(8'h6A, -1, 0, 8'h16, -1); oks++;
    expect_result(0, oks, "R5");
    chk(int'(pay_len) == 1, "R5", "minimal length", int'(pay_len), 1);

    // R5/R6: full buffer, checksum carries into high byte; with gaps (R12)
    gap_every = 3;
    pq = {};
    for (int i = 0; i < PM; i++) pq.push_back(8'hFF);
    send_frame(8'h6A, -1, 0, 8'h16, -1); oks++;
    expect_result(0, oks, "R12");
    chk(int'(pay_len) == PM, "R5", "full payload", int'(pay_len), PM);
    gap_every = 0;
    readback("R10");

    // R5: length one above capacity, and too small
    last_err = 0;
    pq = {};
    for (int i = 0; i <= PM; i++) pq.push_back(8'(i + 1));
    send_frame(8'h6A, -1, 0, 8'h16, 5);
    expect_result(3, oks, "R5");
    last_err = 0;
    send_frame(8'h6A, 6, 0, 8'h16, 5);
    expect_result(3, oks, "R5");
    // R9: results held after failed frames
    chk(cmd_type == 8'hFF, "R9", "cmd held after error", int'(cmd_type), 'hFF);
    chk(int'(pay_len) == PM, "R9", "length held after error", int'(pay_len), PM);

    // R4: wrong direction byte
    last_err = 0;
    pq = {8'h8F, 8'h11};
    send_frame(8'h68, -1, 0, 8'h16, 3);
    expect_result(2, oks, "R4");

    // R2: bad second marker byte
    last_err = 0;
    put(8'h46); put(8'h00); idle(3);
    expect_result(1, oks, "R2");
    // R11: the byte 0xB9 right after an error does not start a frame
    last_err = 0;
    put(8'h46); put(8'h33); put(8'hB9); put(8'h6A); idle(3);
    expect_result(1, oks, "R11");

    // R3: doubled first marker opens a frame without error
    last_err = 0;
    put(8'h46);
    pq = {8'h8D, 8'h5A, 8'hA5};
    send_frame(8'h6A, -1, 0, 8'h16, -1); oks++;
    expect_result(0, oks, "R3");
    chk(cmd_type == 8'h8D, "R3", "command after double marker", int'(cmd_type), 'h8D);

    // R10: a lone 0x46 while hunting drops pay_valid
    put(8'h46); idle(1);
    chk(pay_valid == 1'b0, "R10", "pay_valid after new marker", int'(pay_valid), 0);
    put(8'h01); idle(3);
    expect_result(1, oks, "R10");

    // R6: checksum off by one
    last_err = 0;
    pq = {8'h00, 8'h00, 8'h00, 8'h10};
    send_frame(8'h6A, -1, 1, 8'h16, -1);
    expect_result(4, oks, "R6");

    // R7: wrong end byte
    last_err = 0;
    send_frame(8'h6A, -1, 0, 8'h17, -1);
    expect_result(5, oks, "R7");

    // R2: leading garbage is dropped, then a frame parses
    last_err = 0;
    put(8'h7F); put(8'h7F); put(8'hB9); put(8'h16);
    pq = {8'h50, 8'h07, 8'h00};
    send_frame(8'h6A, -1, 0, 8'h16, -1); oks++;
    expect_result(0, oks, "R2");
    readback("R10");

    idle(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

endmodule